// File: doc/BRIEF.md
# Cartridge Bank-Switching Register File

This block sits on the CPU write path of a game-cartridge memory mapper. It watches every CPU write into the upper 32 KB of the address space and decodes it into a small set of bank registers. Before decoding, the address is reduced by a sparse mask, so many addresses alias onto each register. The registers hold two switchable 8 KB program banks, eight 1 KB character banks, a nametable mirroring code and a slot-swap mode bit.

From these registers the block derives the bank numbers for the four 8 KB program windows (0x8000, 0xA000, 0xC000, 0xE000) and for the eight 1 KB character windows. It also turns a CPU address inside the upper 32 KB, and a PPU pattern-table address, into flat ROM byte addresses. Those translations are combinational, so they can feed ROM address pins directly. The reset input is asynchronous and active low. Its release is synchronised inside the block, so writes take effect from the third rising clock edge after the reset input goes high.

Top module: `cart_bank_regs`

## Requirements
- R1: While in reset and after it, until the first accepted write: character bank k holds k (k = 0..7), the mirroring code is 0, and the program windows 0x8000/0xA000/0xC000/0xE000 hold banks 0, 1, N-2 and N-1, where N is the PRG_BANKS parameter.
- R2: A write address is ANDed with 0xF0CF before any register is decoded. Bits 11:8, 5 and 4 of the address therefore never affect decoding (for example, 0x8F30 acts as 0x8000).
- R3: A write to decoded 0x8000 loads the switchable program bank. With the swap bit clear, that bank appears in window 0x8000 and window 0xC000 shows bank N-2. With the swap bit set, it appears in window 0xC000 and window 0x8000 shows bank N-2.
- R4: A write to decoded 0xA000 loads the bank shown in window 0xA000.
- R5: Window 0xE000 always shows bank N-1.
- R6: A program bank written as data d becomes bank d mod N.
- R7: A write to decoded 0x9000 sets the mirroring code from data[1:0]. The codes are 0 vertical, 1 horizontal, 2 single-screen lower, 3 single-screen upper. Data bits 7:2 are ignored.
- R8: A write to decoded 0x9002 or 0x9080 sets the swap bit from data[1]. The other data bits have no effect.
- R9: Character register k = 2*(A[15:12]-0xB) + A[1] is written at decoded addresses 0xB000-0xE003, where A is the address. With A[0]=0, bits 3:0 are loaded from data[3:0]. With A[0]=1, bits CHR_W-1:4 are loaded from the low bits of data. The other half of the register is kept in both cases.
- R10: Writes with bit 15 clear, writes whose decoded address matches no register, and cycles with the write strobe low change no output.
- R11: For a CPU offset c within the upper 32 KB, the program ROM address is bank(window c[14:13]) * 8192 + c[12:0].
- R12: For a PPU address p, the character ROM address is chr_bank[p[12:10]] * 1024 + p[9:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, release synchronised inside |
| wr_en_i | input | 1 | CPU write strobe, one write per cycle |
| wr_addr_i | input | 16 | CPU write address |
| wr_data_i | input | 8 | CPU write data |
| cpu_addr_i | input | 15 | CPU read offset within the upper 32 KB |
| ppu_addr_i | input | 13 | PPU pattern-table address |
| prg_bank_o | output | 4 x clog2(PRG_BANKS) | Bank number of each 8 KB program window, index 0 = 0x8000 |
| chr_bank_o | output | 8 x CHR_W | Bank number of each 1 KB character window |
| mirror_o | output | 2 | Nametable mirroring code |
| prg_rom_addr_o | output | clog2(PRG_BANKS)+13 | Program ROM byte address for cpu_addr_i |
| chr_rom_addr_o | output | CHR_W+10 | Character ROM byte address for ppu_addr_i |

## Verification
The bench builds the block with PRG_BANKS = 12 and CHR_W = 10. Twelve is not a power of two, so written bank numbers must genuinely wrap, and the fixed banks 10 and 11 differ from any all-ones pattern. A 10-bit character register leaves a 6-bit upper field, so the top two data bits of an upper-half write must be dropped. Random writes carry junk in the masked-off address bits, so every alias path of the decode is exercised against the reference model.

// File: rtl/cart_pkg.sv
package cart_pkg;

  localparam int unsigned NUM_CHR = 8;
  localparam logic [15:0] WR_MASK = 16'hF0CF;

  typedef enum logic [1:0] {
    MIR_VERT  = 2'd0,
    MIR_HORIZ = 2'd1,
    MIR_LOWER = 2'd2,
    MIR_UPPER = 2'd3
  } mirror_e;

  typedef struct packed {
    logic               prg_sw;
    logic               prg_a;
    logic               mirror;
    logic               mode;
    logic [NUM_CHR-1:0] chr_lo;
    logic [NUM_CHR-1:0] chr_hi;
  } wr_strobe_t;

endpackage

// File: rtl/cart_rst_sync.sv
module cart_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/cart_wr_decode.sv
module cart_wr_decode
  import cart_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [15:0] wr_addr_i,
  output wr_strobe_t  strb_o
);
  logic [15:0] masked;
  logic [1:0]  grp;
  logic [2:0]  chr_idx;
  logic        in_chr;

  assign masked  = wr_addr_i & WR_MASK;
  assign grp     = 2'(masked[15:12] - 4'hB);
  assign chr_idx = {grp, masked[1]};
  assign in_chr  = (masked[15:12] >= 4'hB) && (masked[15:12] <= 4'hE)
                   && ((masked & 16'h0FFC) == 16'h0000);

  always_comb begin
    strb_o = '0;
    if (wr_en_i) begin
      strb_o.prg_sw = (masked == 16'h8000);
      strb_o.prg_a  = (masked == 16'hA000);
      strb_o.mirror = (masked == 16'h9000);
      strb_o.mode   = (masked == 16'h9002) || (masked == 16'h9080);
      if (in_chr) begin
        if (masked[0]) strb_o.chr_hi[chr_idx] = 1'b1;
        else           strb_o.chr_lo[chr_idx] = 1'b1;
      end
    end
  end

  // R10
  strobe_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(strb_o));

  // R10
  below_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_addr_i[15]) |-> (strb_o == '0));
endmodule

// File: rtl/cart_chr_regs.sv
module cart_chr_regs
  import cart_pkg::*;
#(
  parameter int unsigned CHR_W = 8
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_CHR-1:0]             lo_we_i,
  input  logic [NUM_CHR-1:0]             hi_we_i,
  input  logic [7:0]                     wr_data_i,
  output logic [NUM_CHR-1:0][CHR_W-1:0]  chr_bank_o
);
  localparam int unsigned HI_W = CHR_W - 4;

  logic [HI_W-1:0] hi_val;
  assign hi_val = HI_W'({4'h0, wr_data_i});

  for (genvar k = 0; k < NUM_CHR; k++) begin : g_chr
    logic [CHR_W-1:0] bank_q, bank_d;
    logic             bank_en;

    assign bank_en = lo_we_i[k] | hi_we_i[k];

    always_comb begin
      bank_d = bank_q;
      if (lo_we_i[k]) bank_d[3:0]       = wr_data_i[3:0];
      if (hi_we_i[k]) bank_d[CHR_W-1:4] = hi_val;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      bank_q <= CHR_W'(k);
      else if (bank_en) bank_q <= bank_d;
    end

    assign chr_bank_o[k] = bank_q;

    // R9
    lo_nibble_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lo_we_i[k] |=> (chr_bank_o[k][3:0] == $past(wr_data_i[3:0])));

    // R9
    hi_keeps_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hi_we_i[k] |=> (chr_bank_o[k][3:0] == $past(chr_bank_o[k][3:0])));
  end
endmodule

// File: rtl/cart_prg_regs.sv
module cart_prg_regs
  import cart_pkg::*;
#(
  parameter int unsigned PRG_BANKS = 32
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  wr_strobe_t                            strb_i,
  input  logic [7:0]                            wr_data_i,
  output logic [3:0][$clog2(PRG_BANKS)-1:0]     prg_bank_o,
  output logic [1:0]                            mirror_o
);
  localparam int unsigned PRG_W = $clog2(PRG_BANKS);
  localparam logic [PRG_W-1:0] LAST_BANK = PRG_W'(PRG_BANKS - 1);
  localparam logic [PRG_W-1:0] PEN_BANK  = PRG_W'(PRG_BANKS - 2);
  localparam logic [PRG_W-1:0] A_RESET   = PRG_W'(1 % PRG_BANKS);

  logic [PRG_W-1:0] wrapped;
  logic [PRG_W-1:0] sw_q, sw_d, a_q, a_d;
  logic             swap_q, swap_d;
  mirror_e          mir_q, mir_d;

  assign wrapped = PRG_W'(32'(wr_data_i) % PRG_BANKS);

  always_comb begin
    sw_d   = strb_i.prg_sw ? wrapped : sw_q;
    a_d    = strb_i.prg_a  ? wrapped : a_q;
    swap_d = strb_i.mode   ? wr_data_i[1] : swap_q;
    mir_d  = strb_i.mirror ? mirror_e'(wr_data_i[1:0]) : mir_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_q   <= '0;
      a_q    <= A_RESET;
      swap_q <= 1'b0;
      mir_q  <= MIR_VERT;
    end else begin
      if (strb_i.prg_sw) sw_q   <= sw_d;
      if (strb_i.prg_a)  a_q    <= a_d;
      if (strb_i.mode)   swap_q <= swap_d;
      if (strb_i.mirror) mir_q  <= mir_d;
    end
  end

  assign prg_bank_o[0] = swap_q ? PEN_BANK : sw_q;
  assign prg_bank_o[1] = a_q;
  assign prg_bank_o[2] = swap_q ? sw_q : PEN_BANK;
  assign prg_bank_o[3] = LAST_BANK;
  assign mirror_o      = mir_q;

  // R3
  sw_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strb_i.prg_sw && !strb_i.mode) |=>
      (32'(swap_q ? prg_bank_o[2] : prg_bank_o[0]) == 32'($past(wr_data_i)) % PRG_BANKS));

  // R4
  a_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strb_i.prg_a |=> (32'(prg_bank_o[1]) == 32'($past(wr_data_i)) % PRG_BANKS));

  // R7
  mirror_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strb_i.mirror |=> $stable(mirror_o));
endmodule

// File: rtl/cart_bank_regs.sv
module cart_bank_regs
  import cart_pkg::*;
#(
  parameter int unsigned PRG_BANKS = 32,
  parameter int unsigned CHR_W     = 8
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic                                   wr_en_i,
  input  logic [15:0]                            wr_addr_i,
  input  logic [7:0]                             wr_data_i,
  input  logic [14:0]                            cpu_addr_i,
  input  logic [12:0]                            ppu_addr_i,
  output logic [3:0][$clog2(PRG_BANKS)-1:0]      prg_bank_o,
  output logic [7:0][CHR_W-1:0]                  chr_bank_o,
  output logic [1:0]                             mirror_o,
  output logic [$clog2(PRG_BANKS)+12:0]          prg_rom_addr_o,
  output logic [CHR_W+9:0]                       chr_rom_addr_o
);
  localparam int unsigned PRG_W = $clog2(PRG_BANKS);

  logic       rst_sn;
  wr_strobe_t strb;

  cart_rst_sync i_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_sn (rst_sn)
  );

  cart_wr_decode i_decode (
    .clk_i     (clk_i),
    .rst_ni    (rst_sn),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .strb_o    (strb)
  );

  cart_prg_regs #(.PRG_BANKS(PRG_BANKS)) i_prg (
    .clk_i      (clk_i),
    .rst_ni     (rst_sn),
    .strb_i     (strb),
    .wr_data_i  (wr_data_i),
    .prg_bank_o (prg_bank_o),
    .mirror_o   (mirror_o)
  );

  cart_chr_regs #(.CHR_W(CHR_W)) i_chr (
    .clk_i      (clk_i),
    .rst_ni     (rst_sn),
    .lo_we_i    (strb.chr_lo),
    .hi_we_i    (strb.chr_hi),
    .wr_data_i  (wr_data_i),
    .chr_bank_o (chr_bank_o)
  );

  logic [PRG_W-1:0] cpu_bank;
  logic [CHR_W-1:0] ppu_bank;

  assign cpu_bank       = prg_bank_o[cpu_addr_i[14:13]];
  assign ppu_bank       = chr_bank_o[ppu_addr_i[12:10]];
  assign prg_rom_addr_o = {cpu_bank, cpu_addr_i[12:0]};
  assign chr_rom_addr_o = {ppu_bank, ppu_addr_i[9:0]};

  // R10
  ignored_write_chk: assert property (@(posedge clk_i) disable iff (!rst_sn)
    (!wr_en_i || !wr_addr_i[15]) |=>
      ($stable(prg_bank_o) && $stable(chr_bank_o) && $stable(mirror_o)));

  // R5
  last_window_chk: assert property (@(posedge clk_i) disable iff (!rst_sn)
    (cpu_addr_i[14:13] == 2'b11) |-> (prg_rom_addr_o[PRG_W+12:13] == PRG_W'(PRG_BANKS - 1)));
endmodule

// File: tb/test_cart_bank_regs.sv
`timescale 1ns/1ps
module test_cart_bank_regs;
  localparam int NB = 12;
  localparam int CW = 10;
  localparam int PW = $clog2(NB);

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic               rst_n;
  logic               wr_en;
  logic [15:0]        wr_addr;
  logic [7:0]         wr_data;
  logic [14:0]        cpu_addr;
  logic [12:0]        ppu_addr;
  logic [3:0][PW-1:0] prg_bank;
  logic [7:0][CW-1:0] chr_bank;
  logic [1:0]         mirror;
  logic [PW+12:0]     prg_rom;
  logic [CW+9:0]      chr_rom;

  cart_bank_regs #(.PRG_BANKS(NB), .CHR_W(CW)) i_cart_bank_regs (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .cpu_addr_i(cpu_addr), .ppu_addr_i(ppu_addr),
    .prg_bank_o(prg_bank), .chr_bank_o(chr_bank), .mirror_o(mirror),
    .prg_rom_addr_o(prg_rom), .chr_rom_addr_o(chr_rom)
  );

  int vectors = 0;
  int fails   = 0;

  // reference model state
  int m_sw, m_a, m_swap, m_mir;
  int m_chr [8];

  function automatic int exp_slot(int s);
    case (s)
      0: return m_swap ? NB - 2 : m_sw;
      1: return m_a;
      2: return m_swap ? m_sw : NB - 2;
      default: return NB - 1;
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sw = 0; m_a = 1; m_swap = 0; m_mir = 0;
      for (int k = 0; k < 8; k++) m_chr[k] = k;
    end else if (wr_en) begin
      int m, d, k;
      m = int'(wr_addr) & 'hF0CF;
      d = int'(wr_data);
      if (m == 'h8000) m_sw = d % NB;
      else if (m == 'hA000) m_a = d % NB;
      else if (m == 'h9000) m_mir = d & 3;
      else if (m == 'h9002 || m == 'h9080) m_swap = (d >> 1) & 1;
      else if ((m >> 12) >= 'hB && (m >> 12) <= 'hE && (m & 'h0FFC) == 0) begin
        k = ((m >> 12) - 'hB) * 2 + ((m >> 1) & 1);
        if (m & 1) m_chr[k] = (m_chr[k] & 15) | ((d << 4) & ((1 << CW) - 1));
        else       m_chr[k] = (m_chr[k] & ~15) | (d & 15);
      end
    end
  end

  // cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    for (int s = 0; s < 4; s++)
      check(s == 3 ? "R5 window E000" : "R3 program window", int'(prg_bank[s]), exp_slot(s));
    for (int k = 0; k < 8; k++) check("R9 character bank", int'(chr_bank[k]), m_chr[k]);
    check("R7 mirroring", int'(mirror), m_mir);
    check("R11 program ROM address", int'(prg_rom),
          exp_slot(int'(cpu_addr[14:13])) * 8192 + int'(cpu_addr[12:0]));
    check("R12 character ROM address", int'(chr_rom),
          m_chr[int'(ppu_addr[12:10])] * 1024 + int'(ppu_addr[9:0]));
  end

  always @(negedge clk) begin
    #2;
    cpu_addr = 15'($urandom);
    ppu_addr = 13'($urandom);
  end

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); #1;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    logic [3:0][PW-1:0] snap_p;
    logic [7:0][CW-1:0] snap_c;
    logic [1:0]         snap_m;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    cpu_addr = '0; ppu_addr = '0;
    repeat (3) @(negedge clk);
    // R1 reset values
    check("R1 slot 8000", int'(prg_bank[0]), 0);
    check("R1 slot A000", int'(prg_bank[1]), 1);
    check("R1 slot C000", int'(prg_bank[2]), NB - 2);
    check("R1 slot E000", int'(prg_bank[3]), NB - 1);
    check("R1 char bank 5", int'(chr_bank[5]), 5);
    check("R1 mirroring", int'(mirror), 0);
    #1 rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R3 switchable bank, swap clear
    wr(16'h8000, 8'd5);
    check("R3 slot 8000", int'(prg_bank[0]), 5);
    check("R3 slot C000 fixed", int'(prg_bank[2]), NB - 2);
    // R4
    wr(16'hA000, 8'd7);
    check("R4 slot A000", int'(prg_bank[1]), 7);
    // R8 swap via 0x9002
    wr(16'h9002, 8'h02);
    check("R8 swap slot 8000", int'(prg_bank[0]), NB - 2);
    check("R8 swap slot C000", int'(prg_bank[2]), 5);
    wr(16'h8000, 8'd3);
    check("R3 swapped slot C000", int'(prg_bank[2]), 3);
    // R8 via 0x9080, bit 1 clear but other bits set
    wr(16'h9080, 8'hFD);
    check("R8 unswap slot 8000", int'(prg_bank[0]), 3);
    // R6 wrap
    wr(16'h8000, 8'd200);
    check("R6 wrap 200", int'(prg_bank[0]), 200 % NB);
    wr(16'hA000, 8'hFF);
    check("R6 wrap 255", int'(prg_bank[1]), 255 % NB);
    // R2 aliases
    wr(16'h8F30, 8'd4);
    check("R2 alias 8F30", int'(prg_bank[0]), 4);
    wr(16'hB130, 8'h0A);
    check("R2 alias B130", int'(chr_bank[0]), 10);
    // R7 mirroring codes with junk upper bits
    for (int v = 0; v < 4; v++) begin
      wr(16'h9000, 8'(8'hFC | v));
      check("R7 mirror code", int'(mirror), v);
    end
    // R9 each character register
    for (int k = 0; k < 8; k++) begin
      logic [15:0] base;
      base = {4'(4'hB + k / 2), 10'b0, 1'(k % 2), 1'b0};
      wr(base, 8'hF3);
      wr(base | 16'h0001, 8'hFF);
      check("R9 char bank full", int'(chr_bank[k]), ((255 << 4) & ((1 << CW) - 1)) | 3);
      wr(base | 16'h0001, 8'h02);
      check("R9 char hi write", int'(chr_bank[k]), 32 + 3);
    end
    // R10 ignored writes
    snap_p = prg_bank; snap_c = chr_bank; snap_m = mirror;
    wr(16'h7000, 8'd9);
    wr(16'hF000, 8'd9);
    wr(16'h9001, 8'd1);
    wr(16'h8004, 8'd9);
    wr(16'hB004, 8'd9);
    @(negedge clk); #1; wr_en = 1'b0; wr_addr = 16'h8000; wr_data = 8'd9;
    @(negedge clk); #1;
    check("R10 program banks", int'(prg_bank != snap_p), 0);
    check("R10 character banks", int'(chr_bank != snap_c), 0);
    check("R10 mirroring", int'(mirror != snap_m), 0);

    // random traffic, model compared every cycle (R2 junk bits included)
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] lows [5];
      logic [15:0] a;
      lows = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h80};
      a = {4'($urandom_range(15, 7)), 4'($urandom), 8'(lows[$urandom % 5] | (8'($urandom) & 8'h30))};
      if ($urandom % 10 == 0) a = 16'($urandom);
      wr(a, 8'($urandom));
    end

    // reset again mid-run (R1)
    @(negedge clk); #1 rst_n = 1'b0;
    @(negedge clk);
    check("R1 re-reset slot 8000", int'(prg_bank[0]), 0);
    check("R1 re-reset char 7", int'(chr_bank[7]), 7);
    finish_run();
  end
endmodule